// File: doc/BRIEF.md
# Dual-Order Burst Address Generator

This block sequences the two least significant bits of a word address over a four-beat memory burst. A load strobe captures a complete starting address. After that, the block walks the low two bits through four positions and then returns to where it began. The upper address bits do not change between loads.

A static order input picks one of two sequences. In interleaved order the low bits are the start bits XOR a 2-bit beat count. In linear order they are the start bits plus the beat count, modulo four. An active-low advance input steps the beat count once per clock edge. While advance is deasserted, the current address repeats, which suspends the burst.

The block drives the full current address and the beat index. Both come from registered state, so after a load edge the new values appear in the cycle that follows.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `addr_o` and `beat_o` are both zero.
- R2: After a clock edge that samples `load_i` high, `addr_o` equals the `addr_i` that was sampled and `beat_o` is 0.
- R3: When `load_i` and an asserted advance (`adv_n_i` low) occur in the same cycle, the load wins: the next cycle shows the loaded address with `beat_o` at 0, including when a burst is reloaded part-way through.
- R4: With `order_il_i` high (interleaved), `addr_o[1:0]` equals the start bits XOR `beat_o`. For start values 0, 1, 2 and 3 the four beats are 0,1,2,3 / 1,0,3,2 / 2,3,0,1 / 3,2,1,0.
- R5: With `order_il_i` low (linear), `addr_o[1:0]` equals (start + `beat_o`) mod 4. For start values 0, 1, 2 and 3 the four beats are 0,1,2,3 / 1,2,3,0 / 2,3,0,1 / 3,0,1,2.
- R6: Each clock edge that samples `adv_n_i` low while `load_i` is low increments `beat_o` by one, modulo 4.
- R7: Each clock edge that samples `adv_n_i` high while `load_i` is low leaves `beat_o` unchanged. If `order_il_i` also stays the same, `addr_o` is unchanged too.
- R8: An advance from the fourth beat wraps the burst: `beat_o` returns to 0 and `addr_o[1:0]` returns to the loaded start bits.
- R9: `addr_o[ADDR_W-1:2]` keeps the loaded value on every edge that samples `load_i` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Captures `addr_i` as the burst start; has priority over advance |
| adv_n_i | input | 1 | Active-low advance; high holds the current beat |
| order_il_i | input | 1 | Static order select: 1 interleaved, 0 linear |
| addr_i | input | ADDR_W | Starting word address |
| addr_o | output | ADDR_W | Current burst address |
| beat_o | output | 2 | Current beat index, 0 to 3 |

## Verification
Every start value from 0 to 3 is tried in both orders. This set of eight bursts separates the XOR mapping from the modulo-4 add: the two agree for start values 0 and 2 and differ for 1 and 3. Suspend cycles are placed at points chosen by a pseudo-random sequence, and each burst is followed by one extra advance. Together these show that holding freezes both the beat and the address, and that the wrap returns to the loaded start rather than to zero. Directed cases then check that a load together with an advance, a reload in the middle of a burst, and a reset in the middle of a burst each reset the beat while the upper address bits follow the loaded value.

// File: rtl/burst_pkg.sv
// Package: shared constants and types for the burst address generator.
// Assumes a fixed burst of four beats, so two low address bits are sequenced.
package burst_pkg;
    localparam int BEAT_W     = 2;
    localparam int BURST_LEN  = 1 << BEAT_W;

    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } burst_order_e;
endpackage

// File: rtl/burst_base_reg.sv
// Module: holds the burst start address captured on a load strobe.
// Assumes the loaded value stays valid until the next load or reset.
module burst_base_reg #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] base_o
);
    // Capture the start address on load, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_o <= '0;
        end else if (load_i) begin
            base_o <= addr_i;
        end
    end
endmodule

// File: rtl/burst_beat_ctr.sv
// Module: beat counter for one burst. Clears on load, steps on active-low
// advance, and holds otherwise. Wraps naturally at the burst length.
module burst_beat_ctr
    import burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_n_i,
    output logic [BEAT_W-1:0] beat_o
);
    // Load has priority over advance; counter rolls over modulo BURST_LEN.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_o <= '0;
        end else if (load_i) begin
            beat_o <= '0;
        end else if (!adv_n_i) begin
            beat_o <= beat_o + 1'b1;
        end
    end
endmodule

// File: rtl/burst_low_map.sv
// Module: maps start bits and beat count to the current low address bits.
// Assumes the order select is static while a burst is running.
module burst_low_map
    import burst_pkg::*;
(
    input  logic              order_il_i,
    input  logic [BEAT_W-1:0] start_i,
    input  logic [BEAT_W-1:0] beat_i,
    output logic [BEAT_W-1:0] low_o
);
    logic [BEAT_W-1:0] il_low;
    logic [BEAT_W-1:0] lin_low;

    // Interleaved order: one XOR per sequenced bit.
    for (genvar gi = 0; gi < BEAT_W; gi++) begin : g_il_bit
        assign il_low[gi] = start_i[gi] ^ beat_i[gi];
    end

    // Linear order: modulo add across the sequenced bits.
    assign lin_low = start_i + beat_i;

    // Select the order requested by the static mode input.
    always_comb begin
        if (burst_order_e'(order_il_i) == ORDER_INTERLEAVED) begin
            low_o = il_low;
        end else begin
            low_o = lin_low;
        end
    end
endmodule

// File: rtl/burst_addr_gen.sv
// Module: top of the dual-order burst address generator. Combines the
// captured base, the beat counter and the order mapping into the current
// address. Outputs change in the cycle after the edge that updated state.
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_n_i,
    input  logic              order_il_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [1:0]        beat_o
);
    localparam int UPPER_W = ADDR_W - BEAT_W;

    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] low_cur;

    burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_i),
        .addr_i (addr_i),
        .base_o (base_q)
    );

    burst_beat_ctr u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .adv_n_i (adv_n_i),
        .beat_o  (beat_q)
    );

    burst_low_map u_map (
        .order_il_i (order_il_i),
        .start_i    (base_q[BEAT_W-1:0]),
        .beat_i     (beat_q),
        .low_o      (low_cur)
    );

    // Upper bits pass through from the base; low bits come from the map.
    assign addr_o = {base_q[ADDR_W-1 -: UPPER_W], low_cur};
    assign beat_o = beat_q;
endmodule

// File: rtl/burst_addr_gen_chk.sv
// Module: property checker for burst_addr_gen, attached through bind.
// Observes ports only; assumes synchronous active-low reset.
module burst_addr_gen_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_i,
    input logic              adv_n_i,
    input logic              order_il_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic [1:0]        beat_o
);
    // R2 / R3: a load shows the new address at beat zero.
    p_load_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (beat_o == 2'd0) && (addr_o == $past(addr_i)));

    // R6: an advance steps the beat by one.
    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_n_i) |=> (beat_o == $past(beat_o) + 2'd1));

    // R7: a suspend holds the beat, and the address while order is steady.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_n_i) |=> $stable(beat_o) &&
            ($stable(order_il_i) ? $stable(addr_o) : 1'b1));

    // R4: in interleaved order, low bits XOR beat stay at the start value.
    p_interleave_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && order_il_i) |=> ((order_il_i && $stable(order_il_i)) ?
            ((addr_o[1:0] ^ beat_o) == $past(addr_o[1:0] ^ beat_o)) : 1'b1));

    // R5: in linear order, low bits minus beat stay at the start value.
    p_linear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !order_il_i) |=> ((!order_il_i && $stable(order_il_i)) ?
            ((addr_o[1:0] - beat_o) == $past(addr_o[1:0] - beat_o)) : 1'b1));

    // R9: upper address bits only change on a load.
    p_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(addr_o[ADDR_W-1:2]));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .adv_n_i    (adv_n_i),
    .order_il_i (order_il_i),
    .addr_i     (addr_i),
    .addr_o     (addr_o),
    .beat_o     (beat_o)
);

// File: tb/burst_addr_gen_bench.sv
`timescale 1ns/1ps
// Bench: table-driven bursts for every start value in both orders with
// pseudo-random suspends, then directed reset, priority and reload cases.
module burst_addr_gen_bench;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          load_i;
    logic          adv_n_i;
    logic          order_il_i;
    logic [AW-1:0] addr_i;
    logic [AW-1:0] addr_o;
    logic [1:0]    beat_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] lfsr = 8'hA5;

    // {order, start[1:0], beat0..beat3 low bits}
    localparam logic [10:0] VEC [8] = '{
        {1'b1, 2'd0, 8'b00_01_10_11},
        {1'b1, 2'd1, 8'b01_00_11_10},
        {1'b1, 2'd2, 8'b10_11_00_01},
        {1'b1, 2'd3, 8'b11_10_01_00},
        {1'b0, 2'd0, 8'b00_01_10_11},
        {1'b0, 2'd1, 8'b01_10_11_00},
        {1'b0, 2'd2, 8'b10_11_00_01},
        {1'b0, 2'd3, 8'b11_00_01_10}
    };

    burst_addr_gen #(.ADDR_W(AW)) u_burst_addr_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .adv_n_i    (adv_n_i),
        .order_il_i (order_il_i),
        .addr_i     (addr_i),
        .addr_o     (addr_o),
        .beat_o     (beat_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
    task automatic step(input logic ld, input logic advn, input logic [AW-1:0] a);
        load_i  = ld;
        adv_n_i = advn;
        addr_i  = a;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [AW-1:0] base;
        logic [1:0]    e;
        rst_n = 1'b0; load_i = 1'b0; adv_n_i = 1'b1; order_il_i = 1'b0; addr_i = '0;
        @(negedge clk);
        addr_i = 20'hFFFFF; load_i = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1 reset addr", 32'(addr_o), 32'h0);
        chk("R1 reset beat", 32'(beat_o), 32'h0);
        rst_n = 1'b1;
        step(1'b0, 1'b1, '0);
        chk("R1 post-reset addr", 32'(addr_o), 32'h0);

        // Table walk: every start value in both orders.
        for (int v = 0; v < 8; v++) begin
            base = {18'h2A5A3 ^ 18'(v * 18'h1111), VEC[v][9:8]};
            order_il_i = VEC[v][10];
            step(1'b1, 1'b1, base);
            chk("R2 load addr", 32'(addr_o), 32'(base));
            chk("R2 load beat", 32'(beat_o), 32'h0);
            for (int b = 1; b < 4; b++) begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                if (lfsr[0]) begin
                    step(1'b0, 1'b1, 20'h0);
                    e = VEC[v][7 - 2*(b-1) -: 2];
                    chk("R7 suspend beat", 32'(beat_o), 32'(b - 1));
                    chk("R7 suspend addr", 32'(addr_o), 32'({base[AW-1:2], e}));
                end
                step(1'b0, 1'b0, 20'h0);
                e = VEC[v][7 - 2*b -: 2];
                chk(VEC[v][10] ? "R4 interleaved low" : "R5 linear low",
                    32'(addr_o[1:0]), 32'(e));
                chk("R6 beat step", 32'(beat_o), 32'(b));
                chk("R9 upper held", 32'(addr_o[AW-1:2]), 32'(base[AW-1:2]));
            end
            step(1'b0, 1'b0, 20'h0);
            chk("R8 wrap low", 32'(addr_o[1:0]), 32'(VEC[v][9:8]));
            chk("R8 wrap beat", 32'(beat_o), 32'h0);
        end

        // R3: load together with advance.
        order_il_i = 1'b0;
        step(1'b1, 1'b0, 20'h12345);
        chk("R3 load+adv addr", 32'(addr_o), 32'h12345);
        chk("R3 load+adv beat", 32'(beat_o), 32'h0);
        step(1'b0, 1'b0, 20'h0);
        step(1'b0, 1'b0, 20'h0);
        chk("R5 linear start1 beat2", 32'(addr_o), 32'h12347);
        // R3: reload part-way through, with advance asserted.
        order_il_i = 1'b1;
        step(1'b1, 1'b0, 20'hABCDE);
        chk("R3 reload addr", 32'(addr_o), 32'hABCDE);
        chk("R3 reload beat", 32'(beat_o), 32'h0);
        step(1'b0, 1'b0, 20'h0);
        chk("R4 interleaved start2 beat1", 32'(addr_o), 32'hABCDF);
        // R7: long suspend.
        for (int k = 0; k < 3; k++) step(1'b0, 1'b1, 20'h55555);
        chk("R7 long suspend addr", 32'(addr_o), 32'hABCDF);
        chk("R7 long suspend beat", 32'(beat_o), 32'h1);
        // R1: reset mid-burst.
        rst_n = 1'b0;
        step(1'b0, 1'b0, 20'h0);
        chk("R1 mid-burst reset addr", 32'(addr_o), 32'h0);
        chk("R1 mid-burst reset beat", 32'(beat_o), 32'h0);
        rst_n = 1'b1;
        step(1'b0, 1'b1, 20'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule